// File: doc/BRIEF.md
# Message-Signaled Interrupt Write Generator

This block sits between a device's internal interrupt sources and its outbound memory-write port. It turns each interrupt request into a single in-band write. The write goes to a target address that all vectors share. Its payload is a 16-bit data word with the vector number merged into the low bits. Configuration sets how many vectors are enabled, chosen as a power of two from 1 to 32. It also sets whether the full 64-bit address or only its lower half is used, which vectors are masked, and whether message generation is enabled at all.

The outbound port is shared with the device's ordinary posted data writes. Those writes pass straight through and always take the port first. An interrupt write is therefore never offered while a data write issued before it is still waiting. When the handler runs, the data it reads is already in memory. Each vector keeps a pending bit. Pending vectors are sent lowest number first, one per accepted write.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset no vector is pending. With no data write offered, `wr_valid` stays low.
- R2: `cfg_vecs` holds log2 of the enabled vector count, so 0 to 5 give 1 to 32 vectors. Any value above 5 counts as 32 vectors.
- R3: An interrupt write carries `cfg_data` in `wr_data[15:0]`. Its low log2(count) bits are replaced by the vector number. `wr_data[31:16]` is zero.
- R4: An interrupt write targets `cfg_addr` when `cfg_addr64` is 1. When `cfg_addr64` is 0, it targets `cfg_addr[31:0]` with the upper 32 bits forced to zero.
- R5: A request on a vector at or above the enabled count is recorded on the highest enabled vector.
- R6: A request on a masked vector sets its pending bit but sends nothing. Once the vector is unmasked, it is sent.
- R7: Among sendable pending vectors, the lowest number is offered, with `wr_msg` high. Its pending bit clears in the cycle `wr_ready` accepts it. A new request for the same vector in that cycle keeps the bit set. A request appears as a write one cycle after it is sampled.
- R8: While `pw_valid` is high, the port carries the data write, `wr_msg` is low, and no interrupt write is offered.
- R9: While `cfg_enable` is low, no interrupt write is offered. Pending bits are held, and new requests are still recorded.
- R10: `pw_ready` follows `wr_ready`. While `pw_valid` is high, `wr_addr` and `wr_data` equal `pw_addr` and `pw_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Global interrupt-message enable |
| cfg_addr64 | input | 1 | Use all 64 target address bits |
| cfg_addr | input | 64 | Shared target address |
| cfg_data | input | 16 | Message data word |
| cfg_vecs | input | 3 | log2 of enabled vector count |
| cfg_mask | input | 32 | Per-vector mask, 1 = masked |
| irq_req | input | 32 | Per-vector request pulses |
| pw_valid | input | 1 | Posted data write offered |
| pw_ready | output | 1 | Posted data write accepted |
| pw_addr | input | 64 | Posted write address |
| pw_data | input | 32 | Posted write data |
| wr_valid | output | 1 | Outbound write valid |
| wr_ready | input | 1 | Outbound write accepted |
| wr_msg | output | 1 | Outbound write is an interrupt message |
| wr_addr | output | 64 | Outbound write address |
| wr_data | output | 32 | Outbound write data |

## Verification
Directed cases exercise each mechanism on its own:
- An out-of-range request, which must land on the top enabled vector.
- An oversized count code.
- A masked-then-unmasked vector.
- Simultaneous requests under a stalled port, which separate priority order from acceptance-driven clearing.
- A data write held against a stalled port, which shows whether a message can overtake it.
- Requests while disabled, which show whether pending bits are held rather than dropped.
- A 32-bit addressing case with nonzero upper address bits, which shows whether the upper half is forced to zero.

Seeded random traffic then mixes sparse multi-bit requests, random back-pressure, held data writes, and periodic changes of count, mask, enable and address width. A bench pending-bit model predicts every outbound field each cycle.

// File: rtl/msi_msg_gen.sv
module msi_msg_gen #(
  parameter int NVEC = 32,
  parameter int AW   = 64,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic            cfg_addr64,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [15:0]     cfg_data,
  input  logic [2:0]      cfg_vecs,
  input  logic [NVEC-1:0] cfg_mask,
  input  logic [NVEC-1:0] irq_req,
  input  logic            pw_valid,
  output logic            pw_ready,
  input  logic [AW-1:0]   pw_addr,
  input  logic [DW-1:0]   pw_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic            wr_msg,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data
);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic [2:0]      lg;
  logic [VW:0]     nv;
  logic [NVEC-1:0] pend, rng, set, cand, clr;
  logic [VW-1:0]   vec;
  logic            have, msg_go;
  logic [15:0]     lowm, mdata;
  logic [AW-1:0]   maddr;

  assign lg = (cfg_vecs > 3'(VW)) ? 3'(VW) : cfg_vecs;
  assign nv = (VW+1)'(1) << lg;

  always_comb begin
    set = '0;
    for (int i = 0; i < NVEC; i++) begin
      rng[i] = (VW+1)'(i) < nv;
      if (irq_req[i]) begin
        if ((VW+1)'(i) < nv) set[i] = 1'b1;
        else                 set[VW'(nv - 1'b1)] = 1'b1;
      end
    end
  end

  assign cand = pend & ~cfg_mask & rng;

  always_comb begin
    have = 1'b0;
    vec  = '0;
    for (int i = NVEC-1; i >= 0; i--) begin
      if (cand[i]) begin
        have = 1'b1;
        vec  = VW'(i);
      end
    end
  end

  assign msg_go = cfg_enable && have && !pw_valid;
  assign lowm   = 16'((17'(1) << lg) - 17'(1));
  assign mdata  = (cfg_data & ~lowm) | 16'(vec);
  assign maddr  = cfg_addr64 ? cfg_addr : AW'(cfg_addr[31:0]);

  assign pw_ready = wr_ready;
  assign wr_valid = pw_valid | msg_go;
  assign wr_msg   = msg_go;
  assign wr_addr  = pw_valid ? pw_addr : maddr;
  assign wr_data  = pw_valid ? pw_data : DW'(mdata);

  assign clr = (msg_go && wr_ready) ? (NVEC'(1) << vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | set;
  end

  a_r8_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> (!wr_msg && wr_valid && pw_ready == wr_ready));
  a_r9_no_msg_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !wr_msg);
  a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && irq_req == '0) |=> pend == $past(pend));
  a_r7_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msg && wr_ready && irq_req == '0) |=> !pend[$past(vec)]);
  a_r4_addr32: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msg && !cfg_addr64) |-> wr_addr[AW-1:32] == '0);
  a_r5_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msg |-> ((VW+1)'(vec) < nv && wr_data[DW-1:16] == '0));
endmodule

// File: tb/msi_msg_gen_test.sv
module msi_msg_gen_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_enable = 1, cfg_addr64 = 1;
  logic [63:0] cfg_addr = 64'hABCD_0123_FEE0_1000;
  logic [15:0] cfg_data = 16'h4AFF;
  logic [2:0]  cfg_vecs = 3'd5;
  logic [31:0] cfg_mask = '0, irq_req = '0;
  logic        pw_valid = 0, wr_ready = 1;
  logic [63:0] pw_addr = '0;
  logic [31:0] pw_data = '0;
  logic        pw_ready, wr_valid, wr_msg;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  int compared = 0, mismatched = 0, cyc = 0;
  logic [31:0] mpend = '0;

  always #5 clk = ~clk;

  msi_msg_gen uut (.clk, .rst_n, .cfg_enable, .cfg_addr64, .cfg_addr, .cfg_data,
    .cfg_vecs, .cfg_mask, .irq_req, .pw_valid, .pw_ready, .pw_addr, .pw_data,
    .wr_valid, .wr_ready, .wr_msg, .wr_addr, .wr_data);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int nvecs();
    return 1 << ((cfg_vecs > 3'd5) ? 5 : int'(cfg_vecs));
  endfunction

  // Checks outputs mid-cycle, then advances the pending model to the next edge.
  task automatic tick(string tag);
    int n = nvecs();
    int v = -1;
    logic [31:0] set = '0;
    logic [15:0] lm = 16'(n - 1);
    string t;
    #2;
    for (int i = n - 1; i >= 0; i--)
      if (mpend[i] && !cfg_mask[i]) v = i;
    t = (tag != "") ? tag : (pw_valid ? "R8" : (!cfg_enable ? "R9" : "R7"));
    chk("R10", 64'(pw_ready), 64'(wr_ready));
    if (pw_valid) begin
      chk(t, 64'({wr_valid, wr_msg}), 64'(2'b10));
      chk("R10", wr_addr, pw_addr);
      chk("R10", 64'(wr_data), 64'(pw_data));
    end else if (cfg_enable && v >= 0) begin
      chk(t, 64'({wr_valid, wr_msg}), 64'(2'b11));
      chk("R3", 64'(wr_data), 64'((cfg_data & ~lm) | 16'(v)));
      chk("R4", wr_addr, cfg_addr64 ? cfg_addr : {32'h0, cfg_addr[31:0]});
    end else
      chk(t, 64'({wr_valid, wr_msg}), 64'(2'b00));
    for (int i = 0; i < 32; i++)
      if (irq_req[i]) set[(i < n) ? i : n - 1] = 1'b1;
    if (!pw_valid && cfg_enable && v >= 0 && wr_ready) mpend[v] = 1'b0;
    mpend = mpend | set;
    @(negedge clk);
    cyc++;
    irq_req = '0;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R1", 64'(wr_valid), 64'h0);
    rst_n = 1;
    tick("R1"); tick("R1");
    // R2: code 7 means 32 vectors
    cfg_vecs = 3'd7; irq_req = 32'h8000_0000; tick("R2"); tick("R2");
    // R5: 4 vectors, vector 9 folds to 3
    cfg_vecs = 3'd2; irq_req = 32'h200; tick("R5"); tick("R5"); tick("R5");
    // R6: masked vector pends, unmask sends
    cfg_mask = 32'h2; irq_req = 32'h2; tick("R6"); tick("R6"); tick("R6");
    cfg_mask = '0; tick("R6"); tick("R6");
    // R8: held data write with stalled port, message waits behind it
    pw_valid = 1; pw_addr = 64'h1234; pw_data = 32'hD00D; wr_ready = 0; irq_req = 32'h1;
    tick("R8"); tick("R8"); tick("R8");
    wr_ready = 1; tick("R8"); pw_valid = 0; tick("R8"); tick("R8");
    // R9: disabled, requests recorded and held
    cfg_enable = 0; irq_req = 32'h5; tick("R9"); tick("R9"); tick("R9");
    cfg_enable = 1; tick("R9"); tick("R9"); tick("R9");
    // R7: simultaneous requests, priority and back-pressure
    cfg_vecs = 3'd3; irq_req = 32'h2A; wr_ready = 0; tick("R7"); tick("R7");
    wr_ready = 1; tick("R7"); irq_req = 32'h2; tick("R7"); tick("R7"); tick("R7"); tick("R7");
    // R4: 32-bit addressing
    cfg_addr64 = 0; irq_req = 32'h4; tick("R4"); tick("R4"); cfg_addr64 = 1;
    for (int k = 0; k < 4000; k++) begin
      if (k % 200 == 0) begin
        cfg_vecs   = 3'($urandom_range(0, 7));
        cfg_addr64 = 1'($urandom_range(0, 1));
        cfg_addr   = {$urandom, $urandom};
        cfg_data   = 16'($urandom);
        cfg_mask   = $urandom & $urandom & $urandom;
        cfg_enable = $urandom_range(0, 9) != 0;
      end
      if (!(pw_valid && !wr_ready)) begin
        pw_valid = $urandom_range(0, 9) < 3;
        pw_addr  = {$urandom, $urandom};
        pw_data  = $urandom;
      end
      wr_ready = $urandom_range(0, 9) < 7;
      if ($urandom_range(0, 7) == 0) irq_req = $urandom & $urandom & $urandom;
      tick("");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule